// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-core countdown timer. Software loads an initial count and picks a power-of-two prescaler. The count then falls by one on every prescaler tick. The timer has its own local-vector entry, which selects one-shot or periodic operation, masks the timer and names the interrupt vector it raises. Expiries are not lost: each one adds to a pending counter. Whenever that counter is nonzero and the timer is unmasked, the block presents the timer vector on a fire interface, and each accepted delivery takes one count away.

Access goes through a single register write port and a registered read port, each selected by a 4-bit selector. The registers are:
- the software-enable register, whose bit 8 is the enable;
- the initial count;
- the live current count, which is read-only;
- the divide configuration;
- six local-vector entries, of which entry 0 belongs to the timer.

Turning software enable off does three things: it masks all six entries, it discards the pending expiries, and it keeps later entry writes masked until enable is turned back on. Address decoding from a system bus, and the interrupt controller that takes the vector, both sit outside this block.

Top module: `core_countdown_timer`

## Requirements
- R1: The divide configuration (selector 3, bits 3:0) gives a code {bit3, bit1, bit0}. The divisor is 2^((code + 1) mod 8), so code 7 divides by 1, code 0 by 2 and code 4 by 32. With initial count V, the expiry comes V*divisor clock edges after the edge that takes the initial-count write.
- R2: A write to the initial count (selector 1) loads the current count with the written value at that edge. The same write clears the pending count and restarts the prescaler from zero. A value of 0 stops the timer, and no expiry follows.
- R3: The current count (selector 2) reads the ticks that remain. After an expiry, a one-shot timer holds 0, while a periodic timer reloads the initial count.
- R4: Timer entry (selector 4) bit 17 selects periodic mode, bit 16 is the mask, bit 12 is delivery status and bits 7:0 are the vector; every other bit reads 0. The other five entries (selectors 5 to 9) keep bits 16, 12 and 10:0.
- R5: Each expiry adds one to the pending count, which saturates at 2^PEND_W-1 (255 by default). fire_valid is high exactly when the timer entry is unmasked and the pending count is nonzero, and fire_vector then carries the entry's vector. fire_ack while fire_valid is high takes one from the count. fire_ack at any other time has no effect.
- R6: A write to the software-enable register (selector 0) with bit 8 clear sets bit 16 in all six entries and clears the pending count. While bit 8 is clear, every entry write is stored with bit 16 set.
- R7: After reset, each entry reads 0x00010000, and the divide configuration, the initial count, the current count and the pending count are all 0. The software-enable register reads 0x000000FF after reset, and a write to it keeps only bits 9:0.
- R8: rd_data returns, one cycle after rd_sel is presented, the register named by that selector. Selectors 10 to 15 read 0, and writes to selector 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register selector for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 4 | Register selector for the read |
| rd_data | output | 32 | Registered read data |
| fire_valid | output | 1 | Timer interrupt is presented |
| fire_vector | output | 8 | Vector of the timer interrupt |
| fire_ack | input | 1 | Delivery accepted; consumes one pending expiry |

## Verification
The results arrive on four schedules:
- A register write changes the stored value, and therefore fire_valid, at the edge that samples it.
- rd_data shows, one edge after rd_sel, the register's value from before that edge.
- The first expiry lands V*divisor edges after the initial-count write, and fire_valid rises right after it.
- An accepted fire_ack lowers the pending count at its own edge.

The reference model in the bench steps in time with the clock edge and follows these same delays. It is compared on every falling edge. The directed checks count whole clock steps from each write, so they sample fire_valid on the last cycle before an expiry and on the first cycle after it.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 4;
  localparam int PS_W   = 7;   // largest divisor is 2^7

  // register selectors
  localparam logic [SEL_W-1:0] SEL_SPUR = 4'd0;
  localparam logic [SEL_W-1:0] SEL_INIT = 4'd1;
  localparam logic [SEL_W-1:0] SEL_CUR  = 4'd2;
  localparam logic [SEL_W-1:0] SEL_DIV  = 4'd3;
  localparam logic [SEL_W-1:0] SEL_ENT0 = 4'd4;

  // field positions
  localparam int BIT_PERIODIC = 17;
  localparam int BIT_MASK     = 16;
  localparam int BIT_SWEN     = 8;

  localparam logic [DATA_W-1:0] TMR_WMASK = 32'h0003_10FF;
  localparam logic [DATA_W-1:0] OTH_WMASK = 32'h0001_17FF;
  localparam logic [DATA_W-1:0] ENT_RST   = 32'h0001_0000;
  localparam logic [9:0]        SPUR_RST  = 10'h0FF;

  // scrambled divide code -> shift amount
  function automatic logic [2:0] div_shift(input logic [3:0] cfg);
    return {cfg[3], cfg[1:0]} + 3'd1;
  endfunction
endpackage

// File: rtl/cct_prescale.sv
module cct_prescale
  import cct_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [2:0] shift,
  output logic       tick
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] span;

  assign span = (PS_W'(1) << shift) - PS_W'(1);
  assign tick = (cnt_q & span) == span;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else                cnt_q <= cnt_q + PS_W'(1);
  end
endmodule

// File: rtl/cct_count.sv
module cct_count #(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic [CNT_W-1:0]  reload_val,
  input  logic              periodic,
  input  logic              tick,
  input  logic              clear,
  input  logic              take,
  output logic [CNT_W-1:0]  cur_q,
  output logic [PEND_W-1:0] pend_q
);
  logic expire;
  logic pend_full;

  assign expire    = !load && tick && (cur_q == CNT_W'(1));
  assign pend_full = (pend_q == {PEND_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
    end else if (load) begin
      cur_q <= load_val;
    end else if (tick && cur_q != '0) begin
      if (cur_q == CNT_W'(1)) cur_q <= periodic ? reload_val : '0;
      else                    cur_q <= cur_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load || clear) begin
      pend_q <= '0;
    end else if (expire && !take) begin
      if (!pend_full) pend_q <= pend_q + PEND_W'(1);
    end else if (take && !expire) begin
      pend_q <= pend_q - PEND_W'(1);
    end
  end
endmodule

// File: rtl/cct_regfile.sv
module cct_regfile
  import cct_pkg::*;
#(
  parameter int NUM_ENT = 6,
  parameter int CNT_W   = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [CNT_W-1:0]                init_q,
  output logic [3:0]                      div_q,
  output logic [9:0]                      spur_q,
  output logic [NUM_ENT-1:0][DATA_W-1:0]  ent_q,
  output logic                            init_load,
  output logic                            swen_clear
);
  logic swen;

  assign swen       = spur_q[BIT_SWEN];
  assign init_load  = wr_en && (wr_sel == SEL_INIT);
  assign swen_clear = wr_en && (wr_sel == SEL_SPUR) && !wr_data[BIT_SWEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= '0;
      div_q  <= '0;
      spur_q <= SPUR_RST;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_SPUR: spur_q <= wr_data[9:0];
        SEL_INIT: init_q <= wr_data[CNT_W-1:0];
        SEL_DIV:  div_q  <= wr_data[3:0];
        default:  ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    localparam logic [DATA_W-1:0] WMASK  = (g == 0) ? TMR_WMASK : OTH_WMASK;
    localparam logic [SEL_W-1:0]  MY_SEL = SEL_ENT0 + SEL_W'(g);
    logic [DATA_W-1:0] ent_r;
    logic [DATA_W-1:0] force_m;

    assign force_m  = swen ? '0 : ENT_RST;
    assign ent_q[g] = ent_r;

    always_ff @(posedge clk) begin
      if (rst)                              ent_r <= ENT_RST;
      else if (swen_clear)                  ent_r <= ent_r | ENT_RST;
      else if (wr_en && wr_sel == MY_SEL)   ent_r <= (wr_data | force_m) & WMASK;
    end
  end
endmodule

// File: rtl/core_countdown_timer.sv
module core_countdown_timer
  import cct_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PEND_W  = 8,
  parameter int NUM_ENT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              fire_valid,
  output logic [7:0]        fire_vector,
  input  logic              fire_ack
);
  localparam int TMR_IDX = 0;

  logic [CNT_W-1:0]               init_q;
  logic [3:0]                     div_q;
  logic [9:0]                     spur_q;
  logic [NUM_ENT-1:0][DATA_W-1:0] ent_q;
  logic                           init_load;
  logic                           swen_clear;
  logic                           tick;
  logic                           take;
  logic [CNT_W-1:0]               cur_q;
  logic [PEND_W-1:0]              pend_q;
  logic [DATA_W-1:0]              tmr_ent;
  logic [DATA_W-1:0]              rd_next;

  cct_regfile #(.NUM_ENT(NUM_ENT), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .init_q(init_q), .div_q(div_q), .spur_q(spur_q), .ent_q(ent_q),
    .init_load(init_load), .swen_clear(swen_clear)
  );

  cct_prescale u_presc (
    .clk(clk), .rst(rst), .restart(init_load),
    .shift(div_shift(div_q)), .tick(tick)
  );

  assign tmr_ent = ent_q[TMR_IDX];

  cct_count #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_count (
    .clk(clk), .rst(rst), .load(init_load), .load_val(wr_data[CNT_W-1:0]),
    .reload_val(init_q), .periodic(tmr_ent[BIT_PERIODIC]), .tick(tick),
    .clear(swen_clear), .take(take), .cur_q(cur_q), .pend_q(pend_q)
  );

  assign fire_valid  = !tmr_ent[BIT_MASK] && (pend_q != '0);
  assign fire_vector = tmr_ent[7:0];
  assign take        = fire_ack && fire_valid;

  always_comb begin
    rd_next = '0;
    case (rd_sel)
      SEL_SPUR: rd_next = DATA_W'(spur_q);
      SEL_INIT: rd_next = DATA_W'(init_q);
      SEL_CUR:  rd_next = DATA_W'(cur_q);
      SEL_DIV:  rd_next = DATA_W'(div_q);
      default: begin
        for (int i = 0; i < NUM_ENT; i++)
          if (rd_sel == SEL_ENT0 + SEL_W'(i)) rd_next = ent_q[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker
  import cct_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [SEL_W-1:0]  rd_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              fire_valid,
  input logic              fire_ack,
  input logic [CNT_W-1:0]  cur,
  input logic [PEND_W-1:0] pend
);
  // R2: an initial-count write loads the countdown
  assert_load_count_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_INIT) |=> (cur == $past(wr_data[CNT_W-1:0])));

  // R2: an initial-count write discards pending expiries
  assert_load_clears_pend_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_INIT) |=> (pend == '0));

  // R3: a stopped count stays at zero until reloaded
  assert_idle_stays_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (cur == '0 && !(wr_en && wr_sel == SEL_INIT)) |=> (cur == '0));

  // R5: an accepted delivery removes exactly one pending expiry
  assert_take_decrements_R5: assert property (@(posedge clk) disable iff (rst)
    (fire_valid && fire_ack && !wr_en && cur != CNT_W'(1))
      |=> (pend == $past(pend) - PEND_W'(1)));

  // R6: turning software enable off silences the timer
  assert_disable_silences_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_SPUR && !wr_data[BIT_SWEN]) |=> !fire_valid);

  // R4: the timer entry never reads back bits outside its fields
  assert_tmr_entry_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_ENT0) |=> ((rd_data & ~TMR_WMASK) == '0));
endmodule

bind core_countdown_timer cct_checker #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_cct_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_sel(rd_sel), .rd_data(rd_data), .fire_valid(fire_valid),
  .fire_ack(fire_ack), .cur(cur_q), .pend(pend_q)
);

// File: tb/core_countdown_timer_test.sv
module core_countdown_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int PEND_MAX   = 255;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_sel = '0;
  logic        fire_ack = 1'b0;
  logic [31:0] rd_data;
  logic        fire_valid;
  logic [7:0]  fire_vector;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  core_countdown_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .fire_valid(fire_valid),
    .fire_vector(fire_vector), .fire_ack(fire_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_spur, m_init, m_cur, m_div, m_rd_exp;
  logic [31:0] m_ent [6];
  logic [3:0]  m_rd_sel;
  int          m_pend, m_presc;

  function automatic logic [31:0] m_read(input logic [3:0] s);
    case (s)
      4'd0: return m_spur;
      4'd1: return m_init;
      4'd2: return m_cur;
      4'd3: return m_div;
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return m_ent[s - 4];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string sel_tag(input logic [3:0] s);
    case (s)
      4'd0: return "R7 enable-register read";
      4'd1: return "R2 initial-count read";
      4'd2: return "R3 current-count read";
      4'd3: return "R1 divide read";
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return "R4 entry read";
      default: return "R8 unmapped read";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_spur = 32'hFF; m_init = 0; m_cur = 0; m_div = 0; m_pend = 0; m_presc = 0;
      for (int k = 0; k < 6; k++) m_ent[k] = 32'h10000;
      m_rd_exp = 0; m_rd_sel = rd_sel;
    end else begin
      int  d;
      bit  tick, load, take, expire, swen_old, swclr, periodic;
      m_rd_exp = m_read(rd_sel);
      m_rd_sel = rd_sel;
      d        = 1 << ((m_div[3] * 4 + m_div[1:0] + 1) % 8);
      tick     = (m_presc % d) == d - 1;
      load     = wr_en && wr_sel == 4'd1;
      take     = fire_ack && !m_ent[0][16] && m_pend > 0;
      expire   = !load && tick && m_cur == 1;
      swen_old = m_spur[8];
      swclr    = wr_en && wr_sel == 4'd0 && !wr_data[8];
      periodic = m_ent[0][17];
      if (load) begin
        m_cur = wr_data; m_presc = 0;
      end else begin
        if (tick && m_cur != 0) m_cur = (m_cur == 1) ? (periodic ? m_init : 0) : m_cur - 1;
        m_presc = (m_presc + 1) % 128;
      end
      if (load || swclr) m_pend = 0;
      else if (expire && !take) m_pend = (m_pend < PEND_MAX) ? m_pend + 1 : PEND_MAX;
      else if (take && !expire) m_pend = m_pend - 1;
      if (wr_en) begin
        case (wr_sel)
          4'd0: m_spur = wr_data & 32'h3FF;
          4'd1: m_init = wr_data;
          4'd3: m_div  = wr_data & 32'hF;
          4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin
            logic [31:0] v;
            v = wr_data | (swen_old ? 32'h0 : 32'h10000);
            m_ent[wr_sel - 4] = v & ((wr_sel == 4'd4) ? 32'h310FF : 32'h117FF);
          end
          default: ;
        endcase
      end
      if (swclr) for (int k = 0; k < 6; k++) m_ent[k] = m_ent[k] | 32'h10000;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic exp_v;
      exp_v = !m_ent[0][16] && m_pend > 0;
      chk("R5 fire_valid vs model", {31'b0, fire_valid}, {31'b0, exp_v});
      if (exp_v) chk("R5 fire_vector vs model", {24'b0, fire_vector}, {24'b0, m_ent[0][7:0]});
      chk(sel_tag(m_rd_sel), rd_data, m_rd_exp);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic waitn(input int n);
    repeat (n) step();
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [31:0] v);
    rd_sel = s;
    step();
    v = rd_data;
  endtask

  task automatic ack();
    fire_ack = 1'b1;
    step();
    fire_ack = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    waitn(3);
    rst = 1'b0;
    step();

    // R7 reset state
    rd(4'd0, v); chk("R7 reset enable register", v, 32'hFF);
    rd(4'd1, v); chk("R7 reset initial count", v, 0);
    rd(4'd2, v); chk("R7 reset current count", v, 0);
    rd(4'd3, v); chk("R7 reset divide", v, 0);
    for (int k = 4; k < 10; k++) begin
      rd(4'(k), v); chk("R7 reset entry masked", v, 32'h10000);
    end
    chk("R7 reset no fire", {31'b0, fire_valid}, 0);

    // R7 enable-register write keeps bits 9:0
    wr(4'd0, 32'hFFFF_F1FF);
    rd(4'd0, v); chk("R7 enable register width", v, 32'h1FF);

    // R4 entry field masks
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, v); chk("R4 timer entry writable bits", v, 32'h310FF);
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, v); chk("R4 other entry writable bits", v, 32'h117FF);
    wr(4'd5, 32'h10000);
    wr(4'd4, 32'h40);
    rd(4'd4, v); chk("R4 timer entry unmasked one-shot", v, 32'h40);

    // R1 divide code 7 -> /1, count 5 -> expiry 5 edges after the write
    wr(4'd3, 32'hB);
    wr(4'd1, 5);
    waitn(4);
    chk("R1 no expiry before 5 edges", {31'b0, fire_valid}, 0);
    step();
    chk("R1 expiry at 5 edges", {31'b0, fire_valid}, 1);
    chk("R5 vector presented", {24'b0, fire_vector}, 32'h40);
    rd(4'd2, v); chk("R3 one-shot holds zero", v, 0);
    waitn(20);
    chk("R5 pending held until acked", {31'b0, fire_valid}, 1);
    ack();
    chk("R5 ack consumes pending", {31'b0, fire_valid}, 0);
    ack();
    chk("R5 ack without pending ignored", {31'b0, fire_valid}, 0);

    // R1 divide code 0 -> /2
    wr(4'd3, 32'h0);
    wr(4'd1, 3);
    waitn(5);
    chk("R1 /2 no expiry before 6 edges", {31'b0, fire_valid}, 0);
    step();
    chk("R1 /2 expiry at 6 edges", {31'b0, fire_valid}, 1);

    // R1 divide code 4 (cfg 8) -> /32
    wr(4'd3, 32'h8);
    chk("R2 initial-count write clears pending", {31'b0, fire_valid}, 1);
    wr(4'd1, 2);
    chk("R2 initial-count write clears pending", {31'b0, fire_valid}, 0);
    waitn(63);
    chk("R1 /32 no expiry before 64 edges", {31'b0, fire_valid}, 0);
    step();
    chk("R1 /32 expiry at 64 edges", {31'b0, fire_valid}, 1);

    // R2 count of zero stops without expiry
    wr(4'd3, 32'hB);
    wr(4'd1, 0);
    waitn(300);
    chk("R2 zero count never expires", {31'b0, fire_valid}, 0);
    rd(4'd2, v); chk("R2 zero count reads zero", v, 0);

    // R3 periodic reload
    wr(4'd4, 32'h20041);
    wr(4'd1, 4);
    rd(4'd2, v); chk("R2 current count loaded", v, 4);
    waitn(20);
    rd(4'd2, v);
    chk("R3 periodic count reloaded (nonzero)", {31'b0, v != 0}, 1);

    // R5 masked expiries accumulate silently
    wr(4'd4, 32'h30041);
    waitn(10);
    chk("R5 masked timer not presented", {31'b0, fire_valid}, 0);
    wr(4'd4, 32'h20041);
    chk("R5 unmask presents pending", {31'b0, fire_valid}, 1);
    chk("R5 periodic vector", {24'b0, fire_vector}, 32'h41);

    // R6 software disable
    wr(4'd4, 32'h40);
    wr(4'd1, 2);
    waitn(5);
    chk("R6 pending before disable", {31'b0, fire_valid}, 1);
    wr(4'd0, 32'h0FF);
    chk("R6 disable silences timer", {31'b0, fire_valid}, 0);
    rd(4'd4, v); chk("R6 disable masks timer entry", v, 32'h10040);
    rd(4'd9, v); chk("R6 disable masks last entry", v, 32'h10000);
    wr(4'd6, 32'h22);
    rd(4'd6, v); chk("R6 write while disabled forced masked", v, 32'h10022);
    wr(4'd0, 32'h1FF);
    wr(4'd4, 32'h40);
    chk("R6 pending discarded by disable", {31'b0, fire_valid}, 0);
    rd(4'd4, v); chk("R6 entry writable again", v, 32'h40);

    // R8 read-only and unmapped selectors
    wr(4'd2, 32'h1234);
    rd(4'd2, v); chk("R8 current count not writable", v, 0);
    rd(4'd15, v); chk("R8 unmapped selector reads zero", v, 0);

    // R5 saturation
    wr(4'd4, 32'h20040);
    wr(4'd3, 32'hB);
    wr(4'd1, 1);
    waitn(300);
    wr(4'd4, 32'h40);
    waitn(4);
    for (int k = 0; k < PEND_MAX - 1; k++) ack();
    chk("R5 saturated count one left", {31'b0, fire_valid}, 1);
    ack();
    chk("R5 saturated count drained", {31'b0, fire_valid}, 0);

    waitn(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule